// File: doc/BRIEF.md
# Write Buffer With Read Bypass

This block sits between a data cache and the next memory level. It accepts writes into a small queue, so the processor keeps running while stores or evicted dirty lines wait for memory. The queued writes then drain to memory one at a time, oldest first.

When the cache misses on a read, the block accepts one read request. In the default mode the requested address is compared with every occupied entry of the queue. A match returns the buffered value straight away, and the youngest matching entry wins. With no match, the read is placed on the memory port ahead of every queued write. A parameter selects a simpler mode instead: the read does no lookup, waits until the queue has fully drained, and only then goes to memory.

The memory port carries one request at a time with a valid/ready handshake. Read data comes back on a separate valid strobe. The block keeps at most one read outstanding.

Top module: `wbuf_bypass`

## Requirements
- R1: After reset, wr_full, rsp_valid and mem_valid are low and rd_ready is high.
- R2: wr_full is high exactly when DEPTH entries are occupied (DEPTH is 4 by default). A write offered while wr_full is high is dropped and never reaches memory.
- R3: With FWD_EN=1, a read accepted when rd_valid and rd_ready are both high is compared with every occupied entry. On a match, rsp_valid is high in the next cycle, rsp_fwd=1 and rsp_data holds the buffered data. No read is sent to memory.
- R4: When several occupied entries hold the read address, rsp_data comes from the one enqueued last.
- R5: With FWD_EN=1, a read that matches nothing appears on the memory port in the cycle after it is accepted, with mem_valid=1, mem_write=0 and mem_addr equal to the read address. Queued writes stay behind it until memory accepts it.
- R6: Queued writes reach memory with mem_write=1, each exactly once, in the order they were enqueued.
- R7: A read served by memory gives rsp_valid=1, rsp_fwd=0 and rsp_data equal to mem_rdata, in the cycle after mem_rvalid.
- R8: A write enqueued in the same cycle as a read request is treated as younger than that read. The read does not see it, and the read reaches memory before that write does.
- R9: With FWD_EN=0, no forwarding happens. A read goes to memory only after every queued write has been accepted, and then returns the memory data.
- R10: rd_ready stays low from the cycle after a read is sent to memory until its response arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Write enqueue request |
| wr_addr | input | AW | Write address |
| wr_data | input | DW | Write data |
| wr_full | output | 1 | Queue full; an offered write is dropped |
| rd_valid | input | 1 | Read-miss request |
| rd_addr | input | AW | Read-miss address |
| rd_ready | output | 1 | Read request can be accepted |
| rsp_valid | output | 1 | Read response strobe |
| rsp_data | output | DW | Read response data |
| rsp_fwd | output | 1 | Response came from the queue |
| mem_valid | output | 1 | Memory request valid |
| mem_write | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Memory request address |
| mem_wdata | output | DW | Memory write data |
| mem_ready | input | 1 | Memory accepts the request |
| mem_rvalid | input | 1 | Memory read data valid |
| mem_rdata | input | DW | Memory read data |

## Verification
The lookup of a read miss and the enqueue of a write can land in the same cycle with the same address. The bench provokes this by raising rd_valid and wr_valid together for one address while memory is held not-ready. The outcome is judged in three ways. The memory port must show the read first. The response must carry the old memory value with rsp_fwd low. A later read, made after the queue drains, must return the new data.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
  typedef enum logic [1:0] {
    RD_IDLE  = 2'd0,
    RD_ISSUE = 2'd1,
    RD_WAIT  = 2'd2
  } rd_state_t;
endpackage

// File: rtl/wbuf_store.sv
// FIFO storage of pending writes; all entries visible for parallel lookup.
module wbuf_store #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int DEPTH = 4,   // power of two
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      enq,
  input  logic [AW-1:0]             enq_addr,
  input  logic [DW-1:0]             enq_data,
  input  logic                      deq,
  output logic [PTR_W-1:0]          head,
  output logic [CNT_W-1:0]          count,
  output logic                      full,
  output logic                      empty,
  output logic [DEPTH-1:0][AW-1:0]  ent_addr,
  output logic [DEPTH-1:0][DW-1:0]  ent_data,
  output logic [DEPTH-1:0]          ent_vld,
  output logic [AW-1:0]             head_addr,
  output logic [DW-1:0]             head_data
);
  logic [PTR_W-1:0] tail;

  always_ff @(posedge clk) begin
    if (rst) begin
      head    <= '0;
      tail    <= '0;
      count   <= '0;
      ent_vld <= '0;
    end else begin
      if (enq) begin
        ent_vld[tail] <= 1'b1;
        tail          <= tail + PTR_W'(1);
      end
      if (deq) begin
        ent_vld[head] <= 1'b0;
        head          <= head + PTR_W'(1);
      end
      case ({enq, deq})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

  // payload registers carry no reset
  always_ff @(posedge clk) begin
    if (enq) begin
      ent_addr[tail] <= enq_addr;
      ent_data[tail] <= enq_data;
    end
  end

  assign full      = (count == CNT_W'(DEPTH));
  assign empty     = (count == '0);
  assign head_addr = ent_addr[head];
  assign head_data = ent_data[head];
endmodule

// File: rtl/wbuf_match.sv
// Parallel address compare; the youngest hit supplies the data.
module wbuf_match #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic [AW-1:0]             look_addr,
  input  logic [PTR_W-1:0]          head,
  input  logic [DEPTH-1:0][AW-1:0]  ent_addr,
  input  logic [DEPTH-1:0][DW-1:0]  ent_data,
  input  logic [DEPTH-1:0]          ent_vld,
  output logic                      hit,
  output logic [DW-1:0]             hit_data
);
  logic [DEPTH-1:0] eq;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign eq[g] = ent_vld[g] && (ent_addr[g] == look_addr);
  end

  always_comb begin
    logic [PTR_W-1:0] idx;
    hit      = |eq;
    hit_data = '0;
    // walk from oldest to youngest so the last match wins
    for (int k = 0; k < DEPTH; k++) begin
      idx = head + PTR_W'(k);
      if (eq[idx]) hit_data = ent_data[idx];
    end
  end
endmodule

// File: rtl/wbuf_rdctl.sv
// Read-miss sequencing and memory port arbitration (reads before writes).
module wbuf_rdctl
  import wbuf_pkg::*;
#(
  parameter int AW     = 32,
  parameter int DW     = 32,
  parameter bit FWD_EN = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_valid,
  input  logic [AW-1:0] rd_addr,
  output logic          rd_ready,
  input  logic          hit,
  input  logic [DW-1:0] hit_data,
  input  logic          empty,
  input  logic [AW-1:0] head_addr,
  input  logic [DW-1:0] head_data,
  output logic          deq,
  output logic          mem_valid,
  output logic          mem_write,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ready,
  input  logic          mem_rvalid,
  input  logic [DW-1:0] mem_rdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic          rsp_fwd,
  output rd_state_t     state
);
  logic [AW-1:0] rd_q;
  logic          read_go;

  always_comb begin
    rd_ready  = (state == RD_IDLE);
    read_go   = (state == RD_ISSUE) && (FWD_EN || empty);
    mem_valid = read_go || !empty;
    mem_write = !read_go;
    mem_addr  = read_go ? rd_q : head_addr;
    mem_wdata = head_data;
    deq       = !read_go && !empty && mem_ready;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= RD_IDLE;
      rd_q      <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      rsp_fwd   <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        RD_IDLE: begin
          if (rd_valid) begin
            if (FWD_EN && hit) begin
              rsp_valid <= 1'b1;
              rsp_data  <= hit_data;
              rsp_fwd   <= 1'b1;
            end else begin
              rd_q  <= rd_addr;
              state <= RD_ISSUE;
            end
          end
        end
        RD_ISSUE: if (read_go && mem_ready) state <= RD_WAIT;
        RD_WAIT: begin
          if (mem_rvalid) begin
            rsp_valid <= 1'b1;
            rsp_data  <= mem_rdata;
            rsp_fwd   <= 1'b0;
            state     <= RD_IDLE;
          end
        end
        default: state <= RD_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wbuf_bypass.sv
module wbuf_bypass
  import wbuf_pkg::*;
#(
  parameter int AW     = 32,
  parameter int DW     = 32,
  parameter int DEPTH  = 4,     // power of two
  parameter bit FWD_EN = 1'b1,  // 0: read waits for an empty queue
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_valid,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          wr_full,
  input  logic          rd_valid,
  input  logic [AW-1:0] rd_addr,
  output logic          rd_ready,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic          rsp_fwd,
  output logic          mem_valid,
  output logic          mem_write,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ready,
  input  logic          mem_rvalid,
  input  logic [DW-1:0] mem_rdata
);
  logic                     enq, deq, empty, hit;
  logic [PTR_W-1:0]         head;
  logic [CNT_W-1:0]         count;
  logic [DEPTH-1:0][AW-1:0] ent_addr;
  logic [DEPTH-1:0][DW-1:0] ent_data;
  logic [DEPTH-1:0]         ent_vld;
  logic [AW-1:0]            head_addr;
  logic [DW-1:0]            head_data, hit_data;
  rd_state_t                rd_state;

  assign enq = wr_valid && !wr_full;

  wbuf_store #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst(rst), .enq(enq), .enq_addr(wr_addr), .enq_data(wr_data),
    .deq(deq), .head(head), .count(count), .full(wr_full), .empty(empty),
    .ent_addr(ent_addr), .ent_data(ent_data), .ent_vld(ent_vld),
    .head_addr(head_addr), .head_data(head_data)
  );

  wbuf_match #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_match (
    .look_addr(rd_addr), .head(head), .ent_addr(ent_addr),
    .ent_data(ent_data), .ent_vld(ent_vld), .hit(hit), .hit_data(hit_data)
  );

  wbuf_rdctl #(.AW(AW), .DW(DW), .FWD_EN(FWD_EN)) u_ctl (
    .clk(clk), .rst(rst), .rd_valid(rd_valid), .rd_addr(rd_addr),
    .rd_ready(rd_ready), .hit(hit), .hit_data(hit_data), .empty(empty),
    .head_addr(head_addr), .head_data(head_data), .deq(deq),
    .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .rsp_fwd(rsp_fwd), .state(rd_state)
  );
endmodule

// File: rtl/wbuf_bypass_chk.sv
module wbuf_bypass_chk
  import wbuf_pkg::*;
#(
  parameter int DW     = 32,
  parameter int DEPTH  = 4,
  parameter bit FWD_EN = 1'b1,
  parameter int CNT_W  = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_full,
  input logic          rd_valid,
  input logic          rd_ready,
  input logic          rsp_valid,
  input logic          rsp_fwd,
  input logic [DW-1:0] rsp_data,
  input logic          mem_valid,
  input logic          mem_write,
  input logic          mem_ready,
  input logic          mem_rvalid,
  input logic [DW-1:0] mem_rdata,
  input logic [CNT_W-1:0] count,
  input logic          enq,
  input logic          deq,
  input rd_state_t     rd_state
);
  a_r2_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (wr_full && !deq) |=> (count == CNT_W'(DEPTH)));

  a_r6_drain_count: assert property (@(posedge clk) disable iff (rst)
    (deq && !enq) |=> (count == $past(count) - CNT_W'(1)));

  a_r6_write_handshake: assert property (@(posedge clk) disable iff (rst)
    deq |-> (mem_valid && mem_write && mem_ready));

  a_r3_fwd_needs_request: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fwd) |-> $past(rd_valid && rd_ready));

  a_r5_read_priority: assert property (@(posedge clk) disable iff (rst)
    (FWD_EN && rd_state == RD_ISSUE) |-> (mem_valid && !mem_write));

  a_r7_mem_response: assert property (@(posedge clk) disable iff (rst)
    (rd_state == RD_WAIT && mem_rvalid) |=>
      (rsp_valid && !rsp_fwd && rsp_data == $past(mem_rdata)));

  a_r9_wait_empty: assert property (@(posedge clk) disable iff (rst)
    (!FWD_EN && mem_valid && !mem_write) |-> (count == '0));

  a_r10_one_read: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !mem_write && mem_ready) |=> !rd_ready);
endmodule

bind wbuf_bypass wbuf_bypass_chk #(
  .DW(DW), .DEPTH(DEPTH), .FWD_EN(FWD_EN), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .wr_full(wr_full), .rd_valid(rd_valid),
  .rd_ready(rd_ready), .rsp_valid(rsp_valid), .rsp_fwd(rsp_fwd),
  .rsp_data(rsp_data), .mem_valid(mem_valid), .mem_write(mem_write),
  .mem_ready(mem_ready), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
  .count(count), .enq(enq), .deq(deq), .rd_state(rd_state)
);

// File: tb/tb_wbuf_bypass.sv
`timescale 1ns/1ps

// Behavioural memory with a transaction log.
module tb_memsim (
  input  logic        clk,
  input  logic        rst,
  input  logic        valid,
  input  logic        write,
  input  logic [31:0] addr,
  input  logic [31:0] wdata,
  input  logic        ready_en,
  output logic        ready,
  output logic        rvalid,
  output logic [31:0] rdata
);
  logic [31:0] mem [64];
  logic [63:0] wrote;
  logic [31:0] log_addr [32];
  logic        log_wr [32];
  int          log_n;

  assign ready = ready_en;

  always @(posedge clk) begin
    if (rst) begin
      wrote  <= '0;
      rvalid <= 1'b0;
      rdata  <= '0;
      log_n  <= 0;
    end else begin
      rvalid <= 1'b0;
      if (valid && ready) begin
        if (log_n < 32) begin
          log_addr[log_n] <= addr;
          log_wr[log_n]   <= write;
          log_n           <= log_n + 1;
        end
        if (write) begin
          mem[addr[7:2]]   <= wdata;
          wrote[addr[7:2]] <= 1'b1;
        end else begin
          rvalid <= 1'b1;
          rdata  <= wrote[addr[7:2]] ? mem[addr[7:2]] : (32'hA500_0000 ^ addr);
        end
      end
    end
  end
endmodule

module tb_wbuf_bypass;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;

  // forwarding instance
  logic        wr_valid = 0, rd_valid = 0, rdy_en = 0;
  logic [31:0] wr_addr = 0, wr_data = 0, rd_addr = 0;
  logic        wr_full, rd_ready, rsp_valid, rsp_fwd;
  logic [31:0] rsp_data;
  logic        mem_valid, mem_write, mem_ready, mem_rvalid;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  wbuf_bypass #(.AW(32), .DW(32), .DEPTH(4), .FWD_EN(1'b1)) dut (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_full(wr_full), .rd_valid(rd_valid),
    .rd_addr(rd_addr), .rd_ready(rd_ready), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .rsp_fwd(rsp_fwd), .mem_valid(mem_valid),
    .mem_write(mem_write), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );
  tb_memsim m1 (
    .clk(clk), .rst(rst), .valid(mem_valid), .write(mem_write),
    .addr(mem_addr), .wdata(mem_wdata), .ready_en(rdy_en),
    .ready(mem_ready), .rvalid(mem_rvalid), .rdata(mem_rdata)
  );

  // wait-for-empty instance
  logic        w_wr_valid = 0, w_rd_valid = 0, w_rdy_en = 0;
  logic [31:0] w_wr_addr = 0, w_wr_data = 0, w_rd_addr = 0;
  logic        w_wr_full, w_rd_ready, w_rsp_valid, w_rsp_fwd;
  logic [31:0] w_rsp_data;
  logic        w_mem_valid, w_mem_write, w_mem_ready, w_mem_rvalid;
  logic [31:0] w_mem_addr, w_mem_wdata, w_mem_rdata;

  wbuf_bypass #(.AW(32), .DW(32), .DEPTH(4), .FWD_EN(1'b0)) dut_w (
    .clk(clk), .rst(rst), .wr_valid(w_wr_valid), .wr_addr(w_wr_addr),
    .wr_data(w_wr_data), .wr_full(w_wr_full), .rd_valid(w_rd_valid),
    .rd_addr(w_rd_addr), .rd_ready(w_rd_ready), .rsp_valid(w_rsp_valid),
    .rsp_data(w_rsp_data), .rsp_fwd(w_rsp_fwd), .mem_valid(w_mem_valid),
    .mem_write(w_mem_write), .mem_addr(w_mem_addr), .mem_wdata(w_mem_wdata),
    .mem_ready(w_mem_ready), .mem_rvalid(w_mem_rvalid), .mem_rdata(w_mem_rdata)
  );
  tb_memsim m2 (
    .clk(clk), .rst(rst), .valid(w_mem_valid), .write(w_mem_write),
    .addr(w_mem_addr), .wdata(w_mem_wdata), .ready_en(w_rdy_en),
    .ready(w_mem_ready), .rvalid(w_mem_rvalid), .rdata(w_mem_rdata)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic push(input logic [31:0] a, input logic [31:0] d);
    wr_valid = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 0;
  endtask

  task automatic wait_rsp();
    for (int i = 0; i < 40 && !rsp_valid; i++) @(negedge clk);
  endtask

  task automatic drain();
    rdy_en = 1;
    for (int i = 0; i < 40 && (mem_valid || !rd_ready); i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 wr_full", wr_full, 0);
    chk("R1 rd_ready", rd_ready, 1);
    chk("R1 rsp_valid", rsp_valid, 0);
    chk("R1 mem_valid", mem_valid, 0);
  endtask

  task automatic t_full_and_bypass();
    int base;
    base = m1.log_n;
    rdy_en = 0;
    push(32'h00, 32'h1111_0000);
    push(32'h04, 32'h1111_0004);
    push(32'h08, 32'h1111_0008);
    chk("R2 not full at 3", wr_full, 0);
    push(32'h0C, 32'h1111_000C);
    chk("R2 full at 4", wr_full, 1);
    push(32'h3C, 32'hDEAD_BEEF);      // dropped
    rd_valid = 1; rd_addr = 32'h20;
    @(negedge clk);
    rd_valid = 0;
    chk("R5 read valid", mem_valid, 1);
    chk("R5 read not write", mem_write, 0);
    chk("R5 read addr", mem_addr, 32'h20);
    rdy_en = 1;
    @(negedge clk);
    chk("R10 rd_ready low", rd_ready, 0);
    wait_rsp();
    chk("R7 rsp valid", rsp_valid, 1);
    chk("R7 rsp data", rsp_data, 32'hA500_0020);
    chk("R7 rsp_fwd", rsp_fwd, 0);
    drain();
    repeat (4) @(negedge clk);
    chk("R2 R6 log count", m1.log_n - base, 5);
    chk("R5 first is read", {31'd0, m1.log_wr[base]}, 0);
    for (int k = 0; k < 4; k++) begin
      chk("R6 write order", m1.log_addr[base + 1 + k], 32'(4 * k));
      chk("R6 is write", {31'd0, m1.log_wr[base + 1 + k]}, 1);
    end
  endtask

  task automatic t_forward();
    int base;
    rdy_en = 0;
    push(32'h10, 32'hD100_0001);
    push(32'h14, 32'hD200_0002);
    push(32'h10, 32'hD300_0003);
    base = m1.log_n;
    rd_valid = 1; rd_addr = 32'h10;
    @(negedge clk);
    rd_valid = 0;
    chk("R3 fwd valid", rsp_valid, 1);
    chk("R3 fwd flag", rsp_fwd, 1);
    chk("R4 youngest", rsp_data, 32'hD300_0003);
    rd_valid = 1; rd_addr = 32'h14;
    @(negedge clk);
    rd_valid = 0;
    chk("R3 single match", rsp_data, 32'hD200_0002);
    chk("R3 no mem read", m1.log_n - base, 0);
    drain();
  endtask

  task automatic t_same_cycle();
    rdy_en = 0;
    wr_valid = 1; wr_addr = 32'h30; wr_data = 32'hC0DE_0030;
    rd_valid = 1; rd_addr = 32'h30;
    @(negedge clk);
    wr_valid = 0; rd_valid = 0;
    chk("R8 read first", mem_write, 0);
    chk("R8 read addr", mem_addr, 32'h30);
    rdy_en = 1;
    wait_rsp();
    chk("R8 old value", rsp_data, 32'hA500_0030);
    chk("R8 not forwarded", rsp_fwd, 0);
    drain();
    rd_valid = 1; rd_addr = 32'h30;
    @(negedge clk);
    rd_valid = 0;
    wait_rsp();
    chk("R8 write landed", rsp_data, 32'hC0DE_0030);
    drain();
  endtask

  task automatic t_wait_mode();
    w_rdy_en = 0;
    w_wr_valid = 1; w_wr_addr = 32'h40; w_wr_data = 32'hE100_0040;
    @(negedge clk);
    w_wr_addr = 32'h44; w_wr_data = 32'hE200_0044;
    @(negedge clk);
    w_wr_valid = 0;
    w_rd_valid = 1; w_rd_addr = 32'h40;
    @(negedge clk);
    w_rd_valid = 0;
    chk("R9 no forward", w_rsp_valid, 0);
    chk("R9 write first", w_mem_write, 1);
    chk("R9 head addr", w_mem_addr, 32'h40);
    w_rdy_en = 1;
    for (int i = 0; i < 40 && !w_rsp_valid; i++) @(negedge clk);
    chk("R9 rsp valid", w_rsp_valid, 1);
    chk("R9 rsp data", w_rsp_data, 32'hE100_0040);
    chk("R9 rsp_fwd", w_rsp_fwd, 0);
    chk("R9 log count", m2.log_n, 3);
    chk("R9 read last", {31'd0, m2.log_wr[2]}, 0);
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_full_and_bypass();
    t_forward();
    t_same_cycle();
    t_wait_mode();
    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule